// File: doc/BRIEF.md
# Capacitive Key Matrix Burst Sequencer

This block produces the digital timing that reads a grid of capacitive keys one key at a time. For each enabled key it sends a train of pulses on a single row drive line, routes the matching column through an analog multiplexer, and opens that path with a short gate pulse that spans each rising edge of the row. It clamps every other column to ground. When the pulse train ends, the row drive pins carry the key's offset code to a resistor ladder. After a settling interval, the block offers an ADC sample request tagged with the key number.

Each key has its own burst length and offset code, held in a small table written through a simple configuration port. A burst length of zero takes the key out of the scan. The table refuses any write that would push the number of enabled keys past a fixed limit. Keys are visited row index first, so key number = column * N_X + row. After the last key position the scan wraps to key 0 and reports the wrap.

The sample request is a valid/ready stream. Once `smp_valid` rises, it stays high, and `smp_key` and the offset code on `x_drive` stay unchanged, until `smp_ready` is seen high on a clock edge. `smp_valid` never depends on `smp_ready`. While the request waits, the scan is stalled. A consumer that holds `smp_ready` high takes every request in its first cycle.

Top module: `cap_key_scanner`

## Requirements
- R1: Keys are visited in increasing key number, where key = col * N_X + row (row = low bits, column = high bits). During a burst, `x_drive` has at most one bit set, that bit is bit `row`, and `y_sel` equals the column.
- R2: The number of rising edges on `x_drive` in a key's burst equals that key's burst length. The range is 1 to MAX_BURST (default 64). Each pulse is LO_CYC cycles low followed by HI_CYC cycles high.
- R3: A key whose burst length is 0 gets no pulses and no sample request. It is passed over in one cycle.
- R4: `y_gate` is high for the last LEAD_CYC cycles of each low phase and the first DWELL_CYC cycles of the following high phase. It is therefore high on the cycle of every row rise and the cycle before it.
- R5: While `y_gate` is high, `y_clamp` is all ones except bit `y_sel`. At all other times `y_clamp` is all ones.
- R6: After the last pulse, `x_is_dac` is high and `x_drive` carries the key's 8-bit offset code for exactly SETTLE_CYC cycles before `smp_valid` rises. `x_is_dac` stays high through the request.
- R7: While `smp_valid` is high and `smp_ready` is low, `smp_valid`, `smp_key` and `x_drive` stay unchanged and no next key starts.
- R8: A burst length or offset written while a key is being scanned does not change that visit. It applies from the key's next visit.
- R9: After reset, keys 0 to KEY_LIMIT-1 have burst length DEF_BURST and offset DEF_OFFSET, and the other keys are disabled. A write that would enable a disabled key while KEY_LIMIT keys are already enabled is ignored. A write with a burst length above MAX_BURST is also ignored.
- R10: `scan_done` pulses for one cycle each time the scan moves on from the last key position back to key 0.
- R11: `integ_rst` is high between bursts, including during reset. It is low from the first low phase of a burst until the sample request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_key | input | 6 | Key number to write |
| cfg_burst | input | 7 | Burst length to write (0 disables the key) |
| cfg_offset | input | 8 | Offset code to write |
| x_drive | output | 8 | Row drive lines; offset code while `x_is_dac` is high |
| x_is_dac | output | 1 | Row lines currently carry the offset code |
| y_sel | output | 3 | Column multiplexer select |
| y_gate | output | 1 | Multiplexer gate enable |
| y_clamp | output | 8 | Per-column clamp to ground, 1 = clamped |
| integ_rst | output | 1 | Integrator reset |
| smp_valid | output | 1 | ADC sample request valid |
| smp_ready | input | 1 | ADC sample request accepted |
| smp_key | output | 6 | Key number of the pending sample |
| scan_done | output | 1 | One-cycle pulse at scan wrap |

## Verification
Four properties are checked on every cycle: a single active row line during bursts, a gate that is already open on the cycle before and the cycle of every row rise, a stalled request that holds its key and code, and the table never exceeding its enable limit. The wrap pulse and the settle-before-request order are checked on every cycle as well. Other behaviours only show over a whole key visit or a whole scan, so only the bench's scenarios can check them: pulse counts per key, the exact gate and settle lengths, skipping of disabled keys, refused enables, and the rule that a mid-visit write applies from the next visit.

// File: rtl/cks_pkg.sv
package cks_pkg;

  typedef enum logic [2:0] {
    ST_SEEK,
    ST_LOW,
    ST_HIGH,
    ST_SETTLE,
    ST_SAMPLE
  } seq_state_t;

  // Cycles needed to cover a time in ns at a clock given in MHz, rounded up.
  function automatic int ns_to_cycles(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/cks_key_table.sv
module cks_key_table #(
  parameter int KEYS       = 64,
  parameter int KEY_W      = 6,
  parameter int LEN_W      = 7,
  parameter int OFF_W      = 8,
  parameter int MAX_BURST  = 64,
  parameter int KEY_LIMIT  = 32,
  parameter int DEF_BURST  = 8,
  parameter int DEF_OFFSET = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [KEY_W-1:0] rd_key,
  output logic [LEN_W-1:0] rd_len,
  output logic [OFF_W-1:0] rd_off
);

  localparam int CW = $clog2(KEYS + 1);
  localparam logic [CW-1:0]    LIM     = CW'(KEY_LIMIT);
  localparam logic [CW-1:0]    RST_CNT = (DEF_BURST == 0) ? '0 : CW'(KEY_LIMIT);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BURST);
  localparam logic [LEN_W-1:0] DEF_LEN = LEN_W'(DEF_BURST);
  localparam logic [OFF_W-1:0] DEF_OFF = OFF_W'(DEF_OFFSET);

  logic [LEN_W-1:0] len_q [KEYS];
  logic [OFF_W-1:0] off_q [KEYS];
  logic [CW-1:0]    en_count;

  logic old_on, new_on, blocked, accept;

  always_comb begin
    old_on  = (len_q[wr_key] != '0);
    new_on  = (wr_len != '0);
    blocked = (wr_len > MAX_LEN) || (!old_on && new_on && (en_count >= LIM));
    accept  = wr_en && !blocked;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < KEYS; k++) begin
        len_q[k] <= (k < KEY_LIMIT) ? DEF_LEN : '0;
        off_q[k] <= DEF_OFF;
      end
      en_count <= RST_CNT;
    end else if (accept) begin
      len_q[wr_key] <= wr_len;
      off_q[wr_key] <= wr_off;
      if (!old_on && new_on)      en_count <= en_count + CW'(1);
      else if (old_on && !new_on) en_count <= en_count - CW'(1);
    end
  end

  assign rd_len = len_q[rd_key];
  assign rd_off = off_q[rd_key];

  // R9: the table never holds more enabled keys than the limit
  p_enable_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_count <= LIM);

endmodule

// File: rtl/cks_scan_cursor.sv
module cks_scan_cursor #(
  parameter int KEYS  = 64,
  parameter int KEY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [KEY_W-1:0] key,
  output logic             wrapped
);

  localparam logic [KEY_W-1:0] LAST = KEY_W'(KEYS - 1);

  logic [KEY_W-1:0] key_q;
  logic             wrap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= advance && (key_q == LAST);
      if (advance) key_q <= (key_q == LAST) ? '0 : key_q + KEY_W'(1);
    end
  end

  assign key     = key_q;
  assign wrapped = wrap_q;

  // R10: the wrap pulse coincides with the cursor sitting on key 0
  p_wrap_to_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (key_q == '0));

endmodule

// File: rtl/cks_burst_engine.sv
module cks_burst_engine
  import cks_pkg::*;
#(
  parameter int LEN_W      = 7,
  parameter int LO_CYC     = 25,
  parameter int HI_CYC     = 25,
  parameter int LEAD_CYC   = 2,
  parameter int DWELL_CYC  = 17,
  parameter int SETTLE_CYC = 800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] key_len,
  input  logic             smp_ready,
  output logic             start,
  output logic             advance,
  output logic             x_on,
  output logic             gate,
  output logic             dac_phase,
  output logic             integ_rst,
  output logic             smp_valid
);

  localparam int MAX_A  = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int MAX_C  = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] LO_END   = CNT_W'(LO_CYC - 1);
  localparam logic [CNT_W-1:0] HI_END   = CNT_W'(HI_CYC - 1);
  localparam logic [CNT_W-1:0] SET_END  = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] GATE_ON  = CNT_W'(LO_CYC - LEAD_CYC);
  localparam logic [CNT_W-1:0] GATE_OFF = CNT_W'(DWELL_CYC);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] pulses;
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_SEEK;
      cnt    <= '0;
      pulses <= '0;
      len_q  <= '0;
    end else begin
      unique case (state)
        ST_SEEK: begin
          if (key_len != '0) begin
            len_q  <= key_len;
            pulses <= '0;
            cnt    <= '0;
            state  <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (cnt == LO_END) begin
            cnt   <= '0;
            state <= ST_HIGH;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_HIGH: begin
          if (cnt == HI_END) begin
            cnt <= '0;
            if (pulses + LEN_W'(1) == len_q) begin
              state <= ST_SETTLE;
            end else begin
              pulses <= pulses + LEN_W'(1);
              state  <= ST_LOW;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_SETTLE: begin
          if (cnt == SET_END) begin
            cnt   <= '0;
            state <= ST_SAMPLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_SAMPLE: begin
          if (smp_ready) state <= ST_SEEK;
        end
        default: state <= ST_SEEK;
      endcase
    end
  end

  always_comb begin
    start     = (state == ST_SEEK) && (key_len != '0);
    advance   = ((state == ST_SEEK) && (key_len == '0)) ||
                ((state == ST_SAMPLE) && smp_ready);
    x_on      = (state == ST_HIGH);
    gate      = ((state == ST_LOW) && (cnt >= GATE_ON)) ||
                ((state == ST_HIGH) && (cnt < GATE_OFF));
    dac_phase = (state == ST_SETTLE) || (state == ST_SAMPLE);
    integ_rst = (state == ST_SEEK);
    smp_valid = (state == ST_SAMPLE);
  end

  // R6: a sample request is always preceded by the offset settle phase
  p_settle_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> $past(dac_phase));

  // R7: a pending request is not withdrawn before acceptance
  p_valid_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> smp_valid);

endmodule

// File: rtl/cap_key_scanner.sv
module cap_key_scanner
  import cks_pkg::*;
#(
  parameter int N_X        = 8,
  parameter int N_Y        = 8,
  parameter int MAX_BURST  = 64,
  parameter int KEY_LIMIT  = 32,
  parameter int DEF_BURST  = 8,
  parameter int DEF_OFFSET = 128,
  parameter int CLK_MHZ    = 100,
  parameter int DWELL_NS   = 167,
  parameter int SETTLE_NS  = 8000,
  parameter int LO_CYC     = 25,
  parameter int HI_CYC     = 25,
  parameter int LEAD_CYC   = 2,
  localparam int X_W       = $clog2(N_X),
  localparam int Y_W       = $clog2(N_Y),
  localparam int KEY_W     = X_W + Y_W,
  localparam int LEN_W     = $clog2(MAX_BURST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [KEY_W-1:0] cfg_key,
  input  logic [LEN_W-1:0] cfg_burst,
  input  logic [N_X-1:0]   cfg_offset,
  output logic [N_X-1:0]   x_drive,
  output logic             x_is_dac,
  output logic [Y_W-1:0]   y_sel,
  output logic             y_gate,
  output logic [N_Y-1:0]   y_clamp,
  output logic             integ_rst,
  output logic             smp_valid,
  input  logic             smp_ready,
  output logic [KEY_W-1:0] smp_key,
  output logic             scan_done
);

  localparam int KEYS       = N_X * N_Y;
  localparam int DWELL_CYC  = ns_to_cycles(DWELL_NS, CLK_MHZ);
  localparam int SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_MHZ);

  logic [KEY_W-1:0] cur_key;
  logic [LEN_W-1:0] rd_len;
  logic [N_X-1:0]   rd_off;
  logic [N_X-1:0]   off_q;
  logic             start, advance, x_on;
  logic [X_W-1:0]   row;
  logic [N_X-1:0]   row_hot;

  cks_key_table #(
    .KEYS(KEYS), .KEY_W(KEY_W), .LEN_W(LEN_W), .OFF_W(N_X),
    .MAX_BURST(MAX_BURST), .KEY_LIMIT(KEY_LIMIT),
    .DEF_BURST(DEF_BURST), .DEF_OFFSET(DEF_OFFSET)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_key(cfg_key), .wr_len(cfg_burst), .wr_off(cfg_offset),
    .rd_key(cur_key), .rd_len(rd_len), .rd_off(rd_off)
  );

  cks_scan_cursor #(.KEYS(KEYS), .KEY_W(KEY_W)) u_cursor (
    .clk(clk), .rst_n(rst_n), .advance(advance),
    .key(cur_key), .wrapped(scan_done)
  );

  cks_burst_engine #(
    .LEN_W(LEN_W), .LO_CYC(LO_CYC), .HI_CYC(HI_CYC), .LEAD_CYC(LEAD_CYC),
    .DWELL_CYC(DWELL_CYC), .SETTLE_CYC(SETTLE_CYC)
  ) u_engine (
    .clk(clk), .rst_n(rst_n), .key_len(rd_len), .smp_ready(smp_ready),
    .start(start), .advance(advance), .x_on(x_on), .gate(y_gate),
    .dac_phase(x_is_dac), .integ_rst(integ_rst), .smp_valid(smp_valid)
  );

  // Offset code is captured with the burst length, so a later write waits
  // for the next visit.
  always_ff @(posedge clk) begin
    if (!rst_n)     off_q <= '0;
    else if (start) off_q <= rd_off;
  end

  assign row     = cur_key[X_W-1:0];
  assign y_sel   = cur_key[KEY_W-1:X_W];
  assign smp_key = cur_key;

  generate
    for (genvar i = 0; i < N_X; i++) begin : g_row
      assign row_hot[i] = (row == X_W'(i));
    end
    for (genvar j = 0; j < N_Y; j++) begin : g_clamp
      assign y_clamp[j] = !(y_gate && (y_sel == Y_W'(j)));
    end
  endgenerate

  always_comb begin
    if (x_is_dac)  x_drive = off_q;
    else if (x_on) x_drive = row_hot;
    else           x_drive = '0;
  end

  // R1: a single row line is active during bursts
  p_one_row_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !x_is_dac |-> $onehot0(x_drive));

  // R4: the gate is open on the cycle of a row rise and the cycle before
  p_gate_spans_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_is_dac && !$past(x_is_dac) && ($past(x_drive) == '0) && (x_drive != '0))
      |-> (y_gate && $past(y_gate)));

  // R7: a stalled request keeps its key and offset code
  p_request_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> ($stable(smp_key) && $stable(x_drive)));

endmodule

// File: tb/test_cap_key_scanner.sv
module test_cap_key_scanner;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_key = '0;
  logic [6:0] cfg_burst = '0;
  logic [7:0] cfg_offset = '0;
  logic       smp_ready = 1'b1;
  logic [7:0] x_drive;
  logic       x_is_dac;
  logic [2:0] y_sel;
  logic       y_gate;
  logic [7:0] y_clamp;
  logic       integ_rst;
  logic       smp_valid;
  logic [5:0] smp_key;
  logic       scan_done;

  localparam int SETTLE = 10;
  localparam int GPP    = 4;   // gate cycles per pulse: lead 1 + dwell 3

  always #5 clk = ~clk;

  cap_key_scanner #(
    .KEY_LIMIT(4), .DEF_BURST(2), .DEF_OFFSET(128), .CLK_MHZ(100),
    .DWELL_NS(30), .SETTLE_NS(100), .LO_CYC(5), .HI_CYC(5), .LEAD_CYC(1)
  ) i_cap_key_scanner (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_key(cfg_key),
    .cfg_burst(cfg_burst), .cfg_offset(cfg_offset), .x_drive(x_drive),
    .x_is_dac(x_is_dac), .y_sel(y_sel), .y_gate(y_gate), .y_clamp(y_clamp),
    .integ_rst(integ_rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_key(smp_key), .scan_done(scan_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Per-visit records captured by the monitor at each new sample request.
  int n = 0;
  int r_key[256], r_pul[256], r_row[256], r_ys[256], r_gate[256];
  int r_set[256], r_off[256], r_bad[256], r_done[256], r_int[256];
  int m_pul, m_row, m_ys, m_gate, m_set, m_bad, m_done, m_int;
  logic [7:0] prev_x;
  logic prev_gate, prev_valid;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_pul = 0; m_row = 0; m_ys = 0; m_gate = 0; m_set = 0;
      m_bad = 0; m_done = 0; m_int = 0;
      prev_x = '0; prev_gate = 1'b0; prev_valid = 1'b0;
    end else begin
      if (scan_done) m_done = 1;
      if (integ_rst) m_int = 1;
      if (integ_rst && (y_gate || smp_valid || (x_drive != 0 && !x_is_dac))) m_bad++;
      if (!y_gate && y_clamp != 8'hFF) m_bad++;
      if (y_gate) m_gate++;
      if (!x_is_dac) begin
        m_row = m_row | int'(x_drive);
        if (x_drive != 0 && prev_x == 0) begin
          m_pul++;
          m_ys = int'(y_sel);
          if (!(y_gate && prev_gate && y_clamp == ~(8'b1 << y_sel))) m_bad++;
        end
      end
      if (x_is_dac && !smp_valid) m_set++;
      if (smp_valid && !prev_valid && n < 256) begin
        r_key[n] = int'(smp_key); r_pul[n] = m_pul; r_row[n] = m_row;
        r_ys[n] = m_ys; r_gate[n] = m_gate; r_set[n] = m_set;
        r_off[n] = int'(x_drive); r_bad[n] = m_bad; r_done[n] = m_done;
        r_int[n] = m_int;
        n++;
        m_pul = 0; m_row = 0; m_gate = 0; m_set = 0; m_bad = 0;
        m_done = 0; m_int = 0;
      end
      prev_x = x_drive; prev_gate = y_gate; prev_valid = smp_valid;
    end
  end

  task automatic next_rec(output int idx);
    int target = n;
    while (n <= target) @(posedge clk);
    idx = target;
  endtask

  task automatic cfg_write(input int key, input int len, input int off);
    @(negedge clk);
    cfg_we = 1'b1; cfg_key = 6'(key); cfg_burst = 7'(len); cfg_offset = 8'(off);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Checks one visit record against the expected key layout and timing.
  task automatic chk_visit(input int i, input int key, input int len, input int off);
    chk(r_key[i] == key, "R1 key order", r_key[i], key);
    chk(r_row[i] == (1 << (key % 8)), "R1 row line", r_row[i], 1 << (key % 8));
    chk(r_ys[i] == key / 8, "R1 column select", r_ys[i], key / 8);
    chk(r_pul[i] == len, "R2 pulse count", r_pul[i], len);
    chk(r_gate[i] == len * GPP, "R4 gate cycles", r_gate[i], len * GPP);
    chk(r_bad[i] == 0, "R5 clamp/gate/R11 integrator", r_bad[i], 0);
    chk(r_set[i] == SETTLE, "R6 settle cycles", r_set[i], SETTLE);
    chk(r_off[i] == off, "R6 offset code", r_off[i], off);
    chk(r_int[i] == 1, "R11 integrator reset between bursts", r_int[i], 1);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(x_drive == 0, "R9 reset x_drive", int'(x_drive), 0);
    chk(!smp_valid, "R9 reset smp_valid", int'(smp_valid), 0);
    chk(y_clamp == 8'hFF, "R5 reset clamp", int'(y_clamp), 255);
    chk(!y_gate, "R4 reset gate", int'(y_gate), 0);
    chk(integ_rst, "R11 reset integrator", int'(integ_rst), 1);
    chk(!scan_done, "R10 reset scan_done", int'(scan_done), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_default_scan;
    int idx;
    for (int k = 0; k < 5; k++) begin
      next_rec(idx);
      chk_visit(idx, k % 4, 2, 128);
      chk(r_done[idx] == (k == 4 ? 1 : 0), "R10 wrap pulse", r_done[idx], k == 4 ? 1 : 0);
    end
  endtask

  task automatic t_len_next_visit;
    int idx, hits = 0;
    @(negedge clk);
    while (!(x_drive == 8'h02 && !x_is_dac)) @(negedge clk);
    cfg_write(1, 7, 128);
    for (int g = 0; g < 10 && hits < 2; g++) begin
      next_rec(idx);
      if (r_key[idx] == 1) begin
        hits++;
        chk(r_pul[idx] == (hits == 1 ? 2 : 7), "R8 write applies next visit",
            r_pul[idx], hits == 1 ? 2 : 7);
      end
    end
    chk(hits == 2, "R8 key revisited", hits, 2);
  endtask

  task automatic wait_wrap(output int idx);
    int g = 0;
    next_rec(idx);
    while (r_done[idx] == 0 && g < 10) begin
      next_rec(idx);
      g++;
    end
  endtask

  task automatic t_skip_zero;
    int idx;
    cfg_write(0, 0, 128);
    wait_wrap(idx);
    wait_wrap(idx);
    chk(r_key[idx] == 1, "R3 disabled key skipped", r_key[idx], 1);
    chk(r_done[idx] == 1, "R10 wrap before first enabled key", r_done[idx], 1);
    next_rec(idx); chk(r_key[idx] == 2, "R3 order after skip", r_key[idx], 2);
    next_rec(idx); chk(r_key[idx] == 3, "R3 order after skip", r_key[idx], 3);
    next_rec(idx); chk(r_key[idx] == 1, "R3 key 0 absent", r_key[idx], 1);
  endtask

  task automatic t_limit;
    int idx;
    cfg_write(9, 3, 8'h5A);
    cfg_write(20, 4, 8'h33);
    cfg_write(10, 100, 8'h11);
    wait_wrap(idx);
    wait_wrap(idx);
    chk(r_key[idx] == 1, "R9 scan start", r_key[idx], 1);
    next_rec(idx); chk(r_key[idx] == 2, "R9 order", r_key[idx], 2);
    next_rec(idx); chk(r_key[idx] == 3, "R9 order", r_key[idx], 3);
    next_rec(idx); chk_visit(idx, 9, 3, 8'h5A);
    next_rec(idx);
    chk(r_key[idx] == 1, "R9 refused enable leaves key 20 and 10 out", r_key[idx], 1);
    chk(r_done[idx] == 1, "R10 wrap after key 9", r_done[idx], 1);
  endtask

  task automatic t_max_burst;
    int idx = 0;
    cfg_write(9, 64, 8'hC3);
    for (int g = 0; g < 10; g++) begin
      next_rec(idx);
      if (r_key[idx] == 9) break;
    end
    chk_visit(idx, 9, 64, 8'hC3);
  endtask

  task automatic t_backpressure;
    int idx, k0, x0;
    @(negedge clk);
    smp_ready = 1'b0;
    while (!smp_valid) @(negedge clk);
    k0 = int'(smp_key); x0 = int'(x_drive);
    for (int c = 0; c < 15; c++) begin
      @(negedge clk);
      chk(smp_valid == 1'b1, "R7 valid held", int'(smp_valid), 1);
      chk(int'(smp_key) == k0, "R7 key held", int'(smp_key), k0);
      chk(int'(x_drive) == x0 && x_is_dac, "R7 offset held", int'(x_drive), x0);
    end
    smp_ready = 1'b1;
    next_rec(idx);
    chk(r_key[idx] == (k0 == 1 ? 2 : k0 == 2 ? 3 : k0 == 3 ? 9 : 1),
        "R7 scan resumes at next key", r_key[idx],
        k0 == 1 ? 2 : k0 == 2 ? 3 : k0 == 3 ? 9 : 1);
  endtask

  initial begin
    t_reset;
    t_default_scan;
    t_len_next_visit;
    t_skip_zero;
    t_limit;
    t_max_burst;
    t_backpressure;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule